// File: doc/BRIEF.md
# Two-Wire Register-Write Slave for a Dual Tap Controller

This block is the serial front end of a two-channel digital tap controller. It watches a two-wire bus (clock and open-drain data), recognises START and STOP, compares the address byte against a fixed nibble and four strapped pins, and then takes an instruction byte and a data byte. The instruction byte selects an operation, a register and a channel. A wiper write takes effect as soon as the data byte is acknowledged. A write to one of the four stored settings per channel is held until STOP and then goes through a timed programming cycle. A counter stands in for the slow memory.

While the programming cycle runs, the slave acknowledges nothing. A host finds out that the cycle has finished by sending START and the address until an acknowledge comes back. A write-permit input guards the stored settings. When the input is low, the data byte of a stored-setting write is not acknowledged. When the input drops between START and the start of the cycle, the write is cancelled. When it drops after the cycle has begun, the write still completes.

Top module: `potwr_i2c_slave`

## Requirements
- R1: After reset, sdaOe is low, busy is low, and every wiper and stored setting reads zero.
- R2: An address byte (MSB first) is acknowledged only when bits [7:4] equal 4'b0101 and bits [3:0] equal addrPins. Acknowledge means sdaOe is high during the ninth SCL high. On a mismatch the slave ignores the bus until the next START.
- R3: After a matched address, the instruction byte is always acknowledged. Its bits [7:4] are the opcode, [3:2] select the stored register and [1:0] select the channel.
- R4: Opcode 4'b1010 writes data bits [5:0] to the wiper of the selected channel when the data byte is acknowledged. This does not depend on wrAllow and does not raise busy.
- R5: Opcode 4'b1100 with wrAllow high acknowledges the data. On the following STOP, busy stays high for exactly PROG_CYCLES clock cycles. Only when the cycle ends does stored register r of channel p take data bits [5:0], at dataRegs[(p*4+r)*6 +: 6].
- R6: While busy is high, a START followed by a matching address is not acknowledged.
- R7: Once busy has fallen, a START followed by a matching address is acknowledged again.
- R8: With wrAllow low, an opcode-1100 transaction still gets acknowledges for the address and the instruction. The data byte gets none, no register changes and busy stays low.
- R9: If wrAllow falls after the data acknowledge of an opcode-1100 write but before STOP, no programming cycle starts and the register keeps its value.
- R10: If wrAllow falls while busy is high, the programming cycle still completes and the register is updated.
- R11: A STOP or START in the middle of a byte abandons the transaction and no register is updated.
- R12: The data byte is not acknowledged and nothing changes when the opcode is neither 1010 nor 1100, or when the channel field is 2 or higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | Pulls the data line low when high |
| addrPins | input | 4 | Strapped low address nibble |
| wrAllow | input | 1 | Write permit for stored settings; low protects them |
| busy | output | 1 | Programming cycle in progress |
| wiperPos | output | 12 | Wiper of channel p at [p*6 +: 6] |
| dataRegs | output | 48 | Stored register r of channel p at [(p*4+r)*6 +: 6] |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except when it forms a START or a STOP. Each SCL phase lasts several system clocks, so the synchronised clock and data edges are never seen in the same cycle as a data change. The bench drives the bus one bit at a time with a fixed half-period of eight clocks. It changes data only on the low phase, it releases data during acknowledge slots, and it changes wrAllow only while SCL is low or the bus is idle.

// File: rtl/potwr_pkg.sv
package potwr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA, ST_DONE
  } busState_e;

  typedef struct packed {
    logic shiftEn;
    logic latchInstr;
    logic writeWcr;
    logic armNv;
    logic startProg;
  } ctlStrobe_t;

  localparam logic [3:0] OP_WIPER_WR  = 4'b1010;
  localparam logic [3:0] OP_STORED_WR = 4'b1100;
endpackage

// File: rtl/potwr_ctrl.sv
module potwr_ctrl
  import potwr_pkg::*;
#(
  parameter logic [3:0] ADDR_FIXED = 4'b0101,
  parameter int NUM_POTS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [3:0] addrPins,
  input  logic       wrAllow,
  input  logic       busy,
  input  logic [7:0] rxByte,
  input  logic [7:0] instrByte,
  output ctlStrobe_t stb,
  output logic       sdaBit,
  output logic       sdaOe
);
  logic [2:0] sclSh, sdaSh;
  busState_e  state;
  logic [3:0] bitCnt;
  logic       ackDrive, armed;
  logic       sclRise, sclFall, startDet, stopDet, byteDone;
  logic       addrOk, potOk, wcrOk, drOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh <= 3'b111;
      sdaSh <= 3'b111;
    end else begin
      sclSh <= {sclSh[1:0], sclIn};
      sdaSh <= {sdaSh[1:0], sdaIn};
    end
  end

  assign sdaBit   = sdaSh[1];
  assign sclRise  = sclSh[1] & ~sclSh[2];
  assign sclFall  = ~sclSh[1] & sclSh[2];
  assign startDet = sclSh[1] & sclSh[2] & ~sdaSh[1] & sdaSh[2];
  assign stopDet  = sclSh[1] & sclSh[2] & sdaSh[1] & ~sdaSh[2];
  assign byteDone = sclFall & ~ackDrive & (bitCnt == 4'd8);

  assign addrOk = (rxByte[7:4] == ADDR_FIXED) && (rxByte[3:0] == addrPins) && !busy;
  assign potOk  = int'(instrByte[1:0]) < NUM_POTS;
  assign wcrOk  = (instrByte[7:4] == OP_WIPER_WR) && potOk;
  assign drOk   = (instrByte[7:4] == OP_STORED_WR) && potOk && wrAllow;

  always_comb begin
    stb.shiftEn    = sclRise && !ackDrive && (bitCnt != 4'd8) &&
                     (state inside {ST_ADDR, ST_INSTR, ST_DATA});
    stb.latchInstr = byteDone && (state == ST_INSTR);
    stb.writeWcr   = byteDone && (state == ST_DATA) && wcrOk;
    stb.armNv      = byteDone && (state == ST_DATA) && drOk;
    stb.startProg  = stopDet && armed && wrAllow && (state == ST_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      armed    <= 1'b0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      armed    <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (!wrAllow) armed <= 1'b0;
      if (stb.shiftEn) bitCnt <= bitCnt + 4'd1;
      if (byteDone) begin
        case (state)
          ST_ADDR: begin
            state    <= addrOk ? ST_INSTR : ST_IDLE;
            ackDrive <= addrOk;
          end
          ST_INSTR: begin
            state    <= ST_DATA;
            ackDrive <= 1'b1;
          end
          ST_DATA: begin
            state    <= (wcrOk || drOk) ? ST_DONE : ST_IDLE;
            ackDrive <= wcrOk || drOk;
            if (drOk) armed <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end else if (sclFall && ackDrive) begin
        ackDrive <= 1'b0;
        bitCnt   <= '0;
      end
    end
  end

  assign sdaOe = ackDrive;

  // R2: an idle slave never pulls the line
  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);
  // R6: nothing is acknowledged during a programming cycle
  a_r6_no_ack_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);
endmodule

// File: rtl/potwr_dpath.sv
module potwr_dpath
  import potwr_pkg::*;
#(
  parameter int TAP_BITS    = 6,
  parameter int NUM_POTS    = 2,
  parameter int DR_PER_POT  = 4,
  parameter int PROG_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t stb,
  input  logic       sdaBit,
  output logic [7:0] rxByte,
  output logic [7:0] instrByte,
  output logic       busy,
  output logic [NUM_POTS*TAP_BITS-1:0]            wiperPos,
  output logic [NUM_POTS*DR_PER_POT*TAP_BITS-1:0] dataRegs
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam int POT_W = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1;
  localparam int RS_W  = (DR_PER_POT > 1) ? $clog2(DR_PER_POT) : 1;

  logic [TAP_BITS-1:0] wiper   [NUM_POTS];
  logic [TAP_BITS-1:0] dataReg [NUM_POTS][DR_PER_POT];
  logic [POT_W-1:0]    pendPot;
  logic [RS_W-1:0]     pendReg;
  logic [TAP_BITS-1:0] pendData;
  logic [CNT_W-1:0]    progCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte    <= '0;
      instrByte <= '0;
      pendPot   <= '0;
      pendReg   <= '0;
      pendData  <= '0;
      progCnt   <= '0;
      for (int p = 0; p < NUM_POTS; p++) begin
        wiper[p] <= '0;
        for (int r = 0; r < DR_PER_POT; r++) dataReg[p][r] <= '0;
      end
    end else begin
      if (stb.shiftEn)    rxByte    <= {rxByte[6:0], sdaBit};
      if (stb.latchInstr) instrByte <= rxByte;
      if (stb.writeWcr)   wiper[instrByte[POT_W-1:0]] <= rxByte[TAP_BITS-1:0];
      if (stb.armNv) begin
        pendPot  <= instrByte[POT_W-1:0];
        pendReg  <= instrByte[2 +: RS_W];
        pendData <= rxByte[TAP_BITS-1:0];
      end
      if (stb.startProg) progCnt <= CNT_W'(PROG_CYCLES);
      else if (progCnt != '0) begin
        progCnt <= progCnt - 1'b1;
        if (progCnt == CNT_W'(1)) dataReg[pendPot][pendReg] <= pendData;
      end
    end
  end

  assign busy = (progCnt != '0);

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
    assign wiperPos[p*TAP_BITS +: TAP_BITS] = wiper[p];
    for (genvar r = 0; r < DR_PER_POT; r++) begin : g_reg
      assign dataRegs[(p*DR_PER_POT+r)*TAP_BITS +: TAP_BITS] = dataReg[p][r];
    end
  end

  // R6: control never launches a cycle on top of a running one
  a_r6_busy_no_start: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.startProg);
  // R5: busy only rises after a start strobe from control
  a_r5_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stb.startProg));
  // R11: stored settings change only at the end of a cycle
  a_r11_regs_only_commit: assert property (@(posedge clk) disable iff (!rstN)
    (progCnt != CNT_W'(1)) |=> $stable(dataRegs));
endmodule

// File: rtl/potwr_i2c_slave.sv
module potwr_i2c_slave
  import potwr_pkg::*;
#(
  parameter logic [3:0] ADDR_FIXED = 4'b0101,
  parameter int TAP_BITS    = 6,
  parameter int NUM_POTS    = 2,
  parameter int DR_PER_POT  = 4,
  parameter int PROG_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [3:0] addrPins,
  input  logic       wrAllow,
  output logic       busy,
  output logic [NUM_POTS*TAP_BITS-1:0]            wiperPos,
  output logic [NUM_POTS*DR_PER_POT*TAP_BITS-1:0] dataRegs
);
  ctlStrobe_t stb;
  logic       sdaBit;
  logic [7:0] rxByte, instrByte;

  potwr_ctrl #(.ADDR_FIXED(ADDR_FIXED), .NUM_POTS(NUM_POTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrPins(addrPins), .wrAllow(wrAllow), .busy(busy),
    .rxByte(rxByte), .instrByte(instrByte), .stb(stb),
    .sdaBit(sdaBit), .sdaOe(sdaOe)
  );

  potwr_dpath #(.TAP_BITS(TAP_BITS), .NUM_POTS(NUM_POTS),
                .DR_PER_POT(DR_PER_POT), .PROG_CYCLES(PROG_CYCLES)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaBit),
    .rxByte(rxByte), .instrByte(instrByte), .busy(busy),
    .wiperPos(wiperPos), .dataRegs(dataRegs)
  );
endmodule

// File: tb/potwr_i2c_slave_tb_top.sv
module potwr_i2c_slave_tb_top;
  localparam int PROG = 200;
  localparam int HP   = 8;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] i;
    logic [7:0] d;
    logic       wp;
    logic [2:0] expAck;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h56, 8'hA0, 8'h2A, 1'b1, 3'b111},  // R4 wiper ch0
    '{8'h56, 8'hA1, 8'hFF, 1'b1, 3'b111},  // R4 wiper ch1, top bits dropped
    '{8'h57, 8'hA0, 8'h11, 1'b1, 3'b000},  // R2 pin mismatch
    '{8'h66, 8'hA0, 8'h11, 1'b1, 3'b000},  // R2 fixed nibble mismatch
    '{8'h56, 8'hA2, 8'h11, 1'b1, 3'b110},  // R12 channel 2
    '{8'h56, 8'h30, 8'h11, 1'b1, 3'b110},  // R12 unknown opcode
    '{8'h56, 8'hC0, 8'h15, 1'b0, 3'b110},  // R8 protected stored write
    '{8'h56, 8'hA0, 8'h05, 1'b0, 3'b111}   // R4 wiper ignores wrAllow
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic wrAllow = 1'b1;
  logic sdaOe, busy;
  logic [11:0] wiperPos;
  logic [47:0] dataRegs;
  logic sdaLine;
  int checks = 0, errors = 0, busyRun = 0;
  logic [5:0] wm [2];
  bit done = 0;

  assign sdaLine = mSda & ~sdaOe;

  potwr_i2c_slave #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrPins(4'b0110), .wrAllow(wrAllow), .busy(busy),
    .wiperPos(wiperPos), .dataRegs(dataRegs)
  );

  always #10 clk = ~clk;
  always @(negedge clk) if (busy) busyRun <= busyRun + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    mSda = 1'b1; waitN(HP); mScl = 1'b1; waitN(HP);
    mSda = 1'b0; waitN(HP); mScl = 1'b0; waitN(HP);
  endtask

  task automatic i2cStop();
    mSda = 1'b0; waitN(HP); mScl = 1'b1; waitN(HP);
    mSda = 1'b1; waitN(HP);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int k = 7; k > 7 - n; k--) begin
      mSda = b[k]; waitN(HP); mScl = 1'b1; waitN(HP); mScl = 1'b0;
    end
    waitN(HP);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int k = 7; k >= 0; k--) begin
      mSda = b[k]; waitN(HP); mScl = 1'b1; waitN(HP); mScl = 1'b0;
    end
    mSda = 1'b1; waitN(HP); mScl = 1'b1; waitN(HP / 2);
    ack = ~sdaLine;
    waitN(HP / 2); mScl = 1'b0; waitN(HP);
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] i, input logic [7:0] d,
                       input bit withStop, output logic [2:0] acks);
    logic ak;
    acks = 3'b000;
    i2cStart();
    sendByte(a, ak); acks[2] = ak;
    if (ak) begin
      sendByte(i, ak); acks[1] = ak;
      if (ak) begin sendByte(d, ak); acks[0] = ak; end
    end
    if (withStop) i2cStop();
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 4 * PROG) begin @(negedge clk); guard++; end
  endtask

  initial begin
    logic [2:0] acks;
    logic ak;
    wm[0] = '0; wm[1] = '0;
    waitN(4); rstN = 1'b1; waitN(4);

    // R1 reset state
    chk(sdaOe == 1'b0, "R1 sdaOe", sdaOe, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(wiperPos == '0, "R1 wipers", wiperPos, 0);
    chk(dataRegs == '0, "R1 stored", dataRegs, 0);

    // R2 R3 R4 R8 R12 table
    for (int v = 0; v < 8; v++) begin
      wrAllow = VECS[v].wp;
      frame(VECS[v].a, VECS[v].i, VECS[v].d, 1'b1, acks);
      waitN(4);
      chk(acks == VECS[v].expAck, $sformatf("R2/R3/R8/R12 acks vec%0d", v), acks, VECS[v].expAck);
      if (VECS[v].expAck == 3'b111 && VECS[v].i[7:4] == 4'b1010)
        wm[VECS[v].i[0]] = VECS[v].d[5:0];
      chk(wiperPos == {wm[1], wm[0]}, $sformatf("R4 wipers vec%0d", v), wiperPos, {wm[1], wm[0]});
      chk(busy == 1'b0 && dataRegs == '0, $sformatf("R8 no stored change vec%0d", v), dataRegs, 0);
    end
    wrAllow = 1'b1;

    // R5 stored write ch1 reg1 and cycle length
    busyRun = 0;
    frame(8'h56, 8'hC5, 8'h57, 1'b1, acks);
    chk(acks == 3'b111, "R5 acks", acks, 3'b111);
    waitN(2);
    chk(busy == 1'b1, "R5 busy after STOP", busy, 1);
    chk(dataRegs == '0, "R5 no update while busy", dataRegs, 0);
    waitIdle(); waitN(2);
    chk(busyRun == PROG, "R5 busy length", busyRun, PROG);
    chk(dataRegs[30 +: 6] == 6'h17, "R5 committed", dataRegs[30 +: 6], 6'h17);

    // R6 R7 polling
    frame(8'h56, 8'hC0, 8'h09, 1'b1, acks);
    waitN(2);
    frame(8'h56, 8'h00, 8'h00, 1'b1, acks);
    chk(acks[2] == 1'b0, "R6 no ack while busy", acks[2], 0);
    waitIdle(); waitN(2);
    i2cStart(); sendByte(8'h56, ak); i2cStop();
    chk(ak == 1'b1, "R7 ack after cycle", ak, 1);
    chk(dataRegs[0 +: 6] == 6'h09, "R7 poll write landed", dataRegs[0 +: 6], 6'h09);

    // R9 permit drops before STOP
    frame(8'h56, 8'hC8, 8'h22, 1'b0, acks);
    wrAllow = 1'b0; waitN(HP);
    i2cStop(); waitN(4);
    wrAllow = 1'b1;
    chk(acks == 3'b111, "R9 acks", acks, 3'b111);
    chk(busy == 1'b0, "R9 no cycle", busy, 0);
    chk(dataRegs[12 +: 6] == 6'h00, "R9 register kept", dataRegs[12 +: 6], 0);

    // R10 permit drops during cycle
    frame(8'h56, 8'hCC, 8'h33, 1'b1, acks);
    waitN(4);
    chk(busy == 1'b1, "R10 cycle started", busy, 1);
    wrAllow = 1'b0;
    waitIdle(); waitN(2);
    wrAllow = 1'b1;
    chk(dataRegs[18 +: 6] == 6'h33, "R10 register written", dataRegs[18 +: 6], 6'h33);

    // R11 STOP mid-byte
    i2cStart(); sendByte(8'h56, ak); sendByte(8'hA0, ak);
    sendBits(8'h3F, 4); i2cStop(); waitN(4);
    chk(wiperPos == {wm[1], wm[0]}, "R11 STOP abort", wiperPos, {wm[1], wm[0]});
    // R11 START mid-byte, then a fresh address only
    i2cStart(); sendByte(8'h56, ak); sendByte(8'hA1, ak);
    sendBits(8'h01, 5);
    i2cStart(); sendByte(8'h56, ak); i2cStop(); waitN(4);
    chk(ak == 1'b1, "R11 restart address acked", ak, 1);
    chk(wiperPos == {wm[1], wm[0]}, "R11 START abort", wiperPos, {wm[1], wm[0]});
    chk(busy == 1'b0 && sdaOe == 1'b0, "R11 idle after abort", {busy, sdaOe}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule